// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the transmitting half of the controller end of a time-division serial audio link. It runs on the bit clock that arrives from the far end and counts that clock to cut the stream into fixed frames of 256 bits. Each frame begins with a 16-bit tag slot and continues with twelve 20-bit data slots. The block drives the frame marker (`sync_o`) high for the whole tag slot and shifts every slot out most significant bit first on one serial line.

On the user side each of the twelve slots has a 20-bit parallel word and a valid flag. Slot 1 carries a control register address, slot 2 the control write data, and slots 3 to 6 four playback sample channels. The remaining slots are free for other streams. All words and flags are copied into a shadow register at the clock edge that opens a frame, so one frame never mixes two sets of data. A one-cycle `frame_start_o` strobe tells the user that the copy has just been taken and that the inputs may now be loaded for the next frame. The tag slot tells the receiver which slots are valid. Every slot marked invalid goes out as zeros. A `halt` input stops the link and holds both lines low.

Top module: `aclink_frame_tx`

## Requirements
- R1: A frame is 256 bit clocks long: a 16-bit tag slot followed by 12 slots of 20 bits. `frame_start_o` is high for exactly the first bit clock of each frame, and only then, so frames repeat every 256 cycles.
- R2: `sync_o` is high for exactly the 16 bit clocks of the tag slot and low for the 240 bit clocks that follow.
- R3: `sync_o`, `sdata_o` and `frame_start_o` change only just after a rising edge of `bclk`. Inputs that change between edges have no effect until the next rising edge.
- R4: Tag bit position 0 (sent first) is 1 when any slot's captured valid flag is 1. Tag positions 1 through 12 carry the captured valid flags of slots 1 through 12 in that order, and 1 means valid.
- R5: Tag positions 13, 14 and 15 (the last three bits of the tag slot) are always 0.
- R6: For a slot whose captured valid flag is 0, all 20 of its bits are sent as 0, whatever its data word holds.
- R7: A valid slot n (1 to 12) is sent MSB first from `slot_data_i[(n-1)*20 +: 20]`. Its first bit goes out at frame bit 16+20*(n-1). Slot 1 is the control address, slot 2 the control write data, and slots 3 to 6 are playback channels 1 to 4.
- R8: Data and valid flags are captured only at the rising edge that starts a frame. Changes to `slot_data_i` or `slot_valid_i` during a frame do not alter that frame.
- R9: While `halt` is high, from the first rising edge at which it is seen high, `sync_o`, `sdata_o` and `frame_start_o` are all 0. At the first rising edge with `halt` low again, a new frame starts from its first tag bit, with fresh captured inputs.
- R10: While `rst_n` is low all outputs are 0. The first frame starts at the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock from the far end |
| rst_n | input | 1 | Active-low reset, synchronous to `bclk` |
| halt | input | 1 | Stop the link and hold the outputs low |
| slot_data_i | input | 240 | Twelve 20-bit slot words; slot 1 in bits 19:0 |
| slot_valid_i | input | 12 | Valid flag per slot; bit 0 is slot 1 |
| frame_start_o | output | 1 | One-cycle strobe on the first bit of each frame |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdata_o | output | 1 | Serial output data, MSB first per slot |

## Verification
If the slot or bit position counter goes wrong, the next `sync_o` pulse comes out with the wrong length, or `frame_start_o` appears away from a 256-cycle boundary. Either shows at the ports within one frame. If the shadow copy is taken at the wrong time or from the wrong slot, the serial data and the tag stop matching the values that were present at the frame-opening edge. The bench compares every one of the 256 bit times against values computed from the slot layout, so the first wrong bit is reported within the frame in which it goes out. A halt that is not honoured, or a restart that does not begin at the first tag bit, shows up on the first bit clock after the `halt` edge.

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx #(
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int TAG_W  = 16
) (
  input  logic                    bclk,
  input  logic                    rst_n,
  input  logic                    halt,
  input  logic [NSLOT*SLOT_W-1:0] slot_data_i,
  input  logic [NSLOT-1:0]        slot_valid_i,
  output logic                    frame_start_o,
  output logic                    sync_o,
  output logic                    sdata_o
);

  localparam int MAXW = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
  localparam int BW   = $clog2(MAXW);
  localparam int SLW  = $clog2(NSLOT + 1);
  localparam int SEQ  = 2 ** BW;

  logic                    active_q;
  logic [SLW-1:0]          slot_q;
  logic [BW-1:0]           bit_q;
  logic [NSLOT*SLOT_W-1:0] data_q;
  logic [NSLOT-1:0]        valid_q;

  wire tag_end   = (slot_q == '0) && (bit_q == BW'(TAG_W - 1));
  wire slot_end  = (bit_q == BW'(SLOT_W - 1));
  wire frame_end = (slot_q == SLW'(NSLOT)) && slot_end;
  wire load      = !active_q || frame_end;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      data_q   <= '0;
      valid_q  <= '0;
    end else if (halt) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      active_q <= 1'b1;
      if (load) begin
        slot_q  <= '0;
        bit_q   <= '0;
        data_q  <= slot_data_i;
        valid_q <= slot_valid_i;
      end else if (tag_end || (slot_q != '0 && slot_end)) begin
        slot_q <= slot_q + 1'b1;
        bit_q  <= '0;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // tag and slot bits laid out in transmit order, indexed by bit_q
  logic [SEQ-1:0]    tag_seq;
  logic [SEQ-1:0]    slot_seq;
  logic [SLOT_W-1:0] cur_word;
  logic              cur_valid;

  always_comb begin
    tag_seq    = '0;
    tag_seq[0] = |valid_q;
    for (int i = 0; i < NSLOT; i++) tag_seq[1+i] = valid_q[i];
  end

  always_comb begin
    cur_word  = '0;
    cur_valid = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_q == SLW'(i + 1)) begin
        cur_word  = data_q[i*SLOT_W +: SLOT_W];
        cur_valid = valid_q[i];
      end
    end
  end

  always_comb begin
    slot_seq = '0;
    for (int j = 0; j < SLOT_W; j++) slot_seq[j] = cur_word[SLOT_W-1-j];
  end

  assign sync_o        = active_q && (slot_q == '0);
  assign frame_start_o = sync_o && (bit_q == '0);
  assign sdata_o       = active_q && ((slot_q == '0) ? tag_seq[bit_q]
                                                     : (cur_valid && slot_seq[bit_q]));

  logic [BW:0] sync_run;
  always_ff @(posedge bclk) begin
    if (!rst_n) sync_run <= '0;
    else        sync_run <= sync_o ? sync_run + 1'b1 : '0;
  end

  AST_SYNC_LEN: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_run != '0 && !sync_o && !$past(halt)) |-> (sync_run == (BW+1)'(TAG_W))); // R2
  AST_SYNC_MAX: assert property (@(posedge bclk) disable iff (!rst_n)
    sync_run <= (BW+1)'(TAG_W)); // R2
  AST_START_ON_SYNC: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(sync_o) |-> frame_start_o); // R1
  AST_RSVD_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_o && bit_q > BW'(NSLOT)) |-> !sdata_o); // R5
  AST_STUFF_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
    (active_q && slot_q != '0 && !cur_valid) |-> !sdata_o); // R6
  AST_HALT_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
    halt |=> (!sync_o && !sdata_o && !frame_start_o)); // R9
  AST_SHADOW_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
    (active_q && !frame_end && !halt) |=> ($stable(data_q) && $stable(valid_q))); // R8

endmodule

// File: tb/sim_aclink_frame_tx.sv
`timescale 1ns/1ps
module sim_aclink_frame_tx;
  localparam int SW = 20;
  localparam int NS = 12;

  logic bclk = 1'b0;
  logic rst_n, halt;
  logic [NS*SW-1:0] slot_data_i;
  logic [NS-1:0]    slot_valid_i;
  logic frame_start_o, sync_o, sdata_o;

  aclink_frame_tx u0 (
    .bclk(bclk), .rst_n(rst_n), .halt(halt),
    .slot_data_i(slot_data_i), .slot_valid_i(slot_valid_i),
    .frame_start_o(frame_start_o), .sync_o(sync_o), .sdata_o(sdata_o)
  );

  always #2.5 bclk = ~bclk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [NS*SW-1:0] nd, cd;
  logic [NS-1:0]    nv, cv;

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bit %0d act=%0b exp=%0b t=%0t", req, k, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] dpat(input int f, input int s);
    logic [31:0] x;
    x = 32'h9E3779B9 * (f * 16 + s + 1);
    return x[27:8];
  endfunction

  function automatic logic [NS-1:0] vpat(input int f);
    case (f % 6)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'hAAA;
      3: return 12'h555;
      4: return 12'h001 << (f % 12);
      default: return 12'h03C;
    endcase
  endfunction

  task automatic drive(input int f, input bit garbage);
    logic [NS*SW-1:0] d;
    for (int s = 0; s < NS; s++) d[s*SW +: SW] = dpat(f, s);
    if (garbage) begin
      slot_data_i  = ~d;
      slot_valid_i = ~vpat(f);
    end else begin
      slot_data_i  = d;
      slot_valid_i = vpat(f);
      nd = d;
      nv = vpat(f);
    end
  endtask

  function automatic logic exp_bit(input int k);
    int s, b;
    if (k == 0) return |cv;
    if (k <= NS) return cv[k-1];
    if (k < 16) return 1'b0;
    s = (k - 16) / SW;
    b = SW - 1 - (k - 16) % SW;
    return cv[s] & cd[s*SW + b];
  endfunction

  // called at the negedge where frame_start_o should be high
  task automatic run_frame(input int nxt);
    logic sd;
    cd = nd;
    cv = nv;
    drive(nxt, 1'b1);
    for (int k = 0; k < 256; k++) begin
      if (k == 200) drive(nxt, 1'b0);  // R8: late change targets next frame only
      chk("R1", frame_start_o, k == 0, k);
      chk("R2", sync_o, k < 16, k);
      if (k < 13)       chk("R4", sdata_o, exp_bit(k), k);
      else if (k < 16)  chk("R5", sdata_o, 1'b0, k);
      else if (cv[(k-16)/SW]) chk("R7", sdata_o, exp_bit(k), k);
      else              chk("R6", sdata_o, 1'b0, k);
      sd = sdata_o;
      #1;
      chk("R3", sdata_o, sd, k);
      @(negedge bclk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    logic sd;
    rst_n = 1'b0;
    halt  = 1'b0;
    drive(0, 1'b0);
    repeat (3) @(negedge bclk);
    chk("R10", sync_o, 1'b0, -1);
    chk("R10", sdata_o, 1'b0, -1);
    chk("R10", frame_start_o, 1'b0, -1);
    rst_n = 1'b1;
    @(negedge bclk);
    chk("R10", frame_start_o, 1'b1, 0);
    for (int f = 1; f <= 12; f++) run_frame(f);
    repeat (40) @(negedge bclk);
    sd = sdata_o;
    halt = 1'b1;
    #1;
    chk("R3", sdata_o, sd, 40);
    @(negedge bclk);
    drive(13, 1'b0);
    for (int c = 0; c < 20; c++) begin
      chk("R9", sync_o, 1'b0, c);
      chk("R9", sdata_o, 1'b0, c);
      chk("R9", frame_start_o, 1'b0, c);
      @(negedge bclk);
    end
    halt = 1'b0;
    @(negedge bclk);
    chk("R9", frame_start_o, 1'b1, 0);
    run_frame(14);
    run_frame(15);
    finish_run();
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end
endmodule